// File: doc/BRIEF.md
# Masked Vector Gather Engine

The engine loads one 256-bit vector register from up to eight scattered memory locations. A start pulse captures several inputs: a base address, a 256-bit vector of per-lane index offsets, an index scale, a per-lane mask, an element-width select and the current destination contents. The element-width select gives either eight 32-bit lanes or four 64-bit lanes. The engine then walks the set mask bits from lane 0 upward. For each set bit it issues one read on a request/acknowledge memory port and writes the returned data into that lane.

The mask is the only record of progress. A bit clears in the same cycle that its lane's data lands in the destination, and the operation finishes when the mask is all zeros. A gather that is split into pieces therefore resumes correctly. The caller feeds the remaining mask and the partially filled destination back in, and the result is the same as one uninterrupted gather. Lanes whose mask bit is clear keep the destination contents supplied at start.

Top module: `gather_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low, and mask_o and dst_o are zero.
- R2: With wide_i = 0 there are eight 32-bit lanes. Lane i takes its index from idx_i[32i+31:32i] and its data from mem_rdata_i[31:0] into dst_o[32i+31:32i]. Its read address is base_i + (index << scale_i) modulo 2^AW, where scale_i codes 0..3 mean factors 1, 2, 4 and 8.
- R3: With wide_i = 1 there are four 64-bit lanes. Lane i takes its index from idx_i[64i+63:64i], truncated to AW bits after scaling, and writes mem_rdata_i into dst_o[64i+63:64i]. Mask bits 7..4 are treated as zero and cause no request.
- R4: Only one request is outstanding at a time. The set lanes are serviced in ascending lane order, and mem_req_o and mem_addr_o are held stable until mem_ack_i is sampled high.
- R5: A lane's mask bit, visible on mask_o, clears in the same clock edge at which its data is written. No mask bit changes in a cycle without an acknowledge.
- R6: Lanes whose mask bit is zero at start keep the dst_i contents captured at start.
- R7: If the effective start mask is all zeros, done_o is high in the cycle right after the start edge and no memory request is issued.
- R8: done_o is a one-cycle pulse in the cycle after the last lane's data is written. In that cycle dst_o holds the final value and mask_o is zero, and busy_o falls after it.
- R9: start_i is ignored while busy_o is high, including the done_o cycle.
- R10: Gathering with mask A and then with mask B, feeding the first result back as dst_i, gives the same destination as one gather with mask A|B, provided A and B are disjoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| wide_i | input | 1 | 0: eight 32-bit lanes, 1: four 64-bit lanes |
| scale_i | input | 2 | Index scale code: factor 1 << scale_i |
| base_i | input | AW | Base address |
| idx_i | input | 256 | Per-lane index offsets |
| mask_i | input | 8 | Per-lane fetch mask |
| dst_i | input | 256 | Destination contents at start |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | AW | Read address |
| mem_wide_o | output | 1 | Read size: 0 for 32-bit, 1 for 64-bit |
| mem_ack_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 64 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | 8 | Remaining lanes to fetch |
| dst_o | output | 256 | Destination register value |

## Verification
The assertions check several rules on every cycle. A request and its address hold while they wait for an acknowledge. The mask only loses bits, at most one per cycle and never without an acknowledge. A busy operation stays busy until done, and done lasts exactly one cycle. The bench scenarios are needed for the rest: the address arithmetic for each width and scale, the ascending service order, the untouched lanes keeping their old contents, the zero-mask shortcut, and the split-and-resume equivalence. These are shown by sweeping every 32-bit mask and every 64-bit mask across all scales and several memory latencies.

// File: rtl/gather_engine.sv
module gather_engine #(
  parameter int AW = 32,
  parameter int VW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wide_i,
  input  logic [1:0]    scale_i,
  input  logic [AW-1:0] base_i,
  input  logic [VW-1:0] idx_i,
  input  logic [VW/32-1:0] mask_i,
  input  logic [VW-1:0] dst_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wide_o,
  input  logic          mem_ack_i,
  input  logic [63:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [VW/32-1:0] mask_o,
  output logic [VW-1:0] dst_o
);
  localparam int NL = VW / 32;
  localparam int NW = VW / 64;
  localparam int LW = $clog2(NL);
  localparam logic [NL-1:0] WIDE_LANES = {{(NL-NW){1'b0}}, {NW{1'b1}}};

  logic          run_q, wide_q;
  logic [1:0]    scale_q;
  logic [AW-1:0] base_q;
  logic [VW-1:0] idx_q, dst_q;
  logic [NL-1:0] mask_q;

  logic [LW-1:0] lane;
  logic [LW-2:0] lane64;
  logic [63:0]   off, addr;
  logic          take;

  always_comb begin
    lane = '0;
    for (int i = NL - 1; i >= 0; i--)
      if (mask_q[i]) lane = LW'(i);
  end

  assign lane64 = lane[LW-2:0];
  assign off    = wide_q ? idx_q[lane64*64 +: 64] : {32'b0, idx_q[lane*32 +: 32]};
  assign addr   = {{(64-AW){1'b0}}, base_q} + (off << scale_q);
  assign take   = run_q && (mask_q != '0) && mem_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wide_q  <= 1'b0;
      scale_q <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      dst_q   <= '0;
      mask_q  <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q   <= 1'b1;
        wide_q  <= wide_i;
        scale_q <= scale_i;
        base_q  <= base_i;
        idx_q   <= idx_i;
        dst_q   <= dst_i;
        mask_q  <= wide_i ? (mask_i & WIDE_LANES) : mask_i;
      end
    end else if (mask_q == '0) begin
      run_q <= 1'b0;
    end else if (take) begin
      mask_q[lane] <= 1'b0;
      if (wide_q) dst_q[lane64*64 +: 64] <= mem_rdata_i;
      else        dst_q[lane*32 +: 32]   <= mem_rdata_i[31:0];
    end
  end

  assign mem_req_o  = run_q && (mask_q != '0);
  assign mem_addr_o = addr[AW-1:0];
  assign mem_wide_o = wide_q;
  assign busy_o     = run_q;
  assign done_o     = run_q && (mask_q == '0);
  assign mask_o     = mask_q;
  assign dst_o      = dst_q;
endmodule

// File: rtl/gather_engine_chk.sv
module gather_engine_chk #(
  parameter int AW = 32,
  parameter int NL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [NL-1:0] mask_o
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  a_r5_mask_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o && !mem_ack_i |=> $stable(mask_o));

  a_r5_one_lane_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> ($countones(mask_o ^ $past(mask_o)) <= 1)
                          && ((mask_o & ~$past(mask_o)) == '0));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);
endmodule

bind gather_engine gather_engine_chk #(.AW(AW), .NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i),
  .mem_addr_o(mem_addr_o), .mask_o(mask_o)
);

// File: tb/tb_gather_engine.sv
`timescale 1ns/1ps
module tb_gather_engine;
  localparam int AW = 32;
  localparam int VW = 256;

  logic clk = 0, rst_n = 0, start = 0, wide = 0, ack = 0;
  logic [1:0] scale = 0;
  logic [AW-1:0] base = 0;
  logic [VW-1:0] idx = 0, dst_in = 0;
  logic [7:0] mask = 0;
  logic [63:0] rdata = 0;
  logic mem_req, mem_wide, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mask_o;
  logic [VW-1:0] dst_o;

  int checks = 0, fails = 0, lat = 0, nreq = 0;
  logic [AW-1:0] alog [0:15];

  always #2.5 clk = ~clk;

  gather_engine #(.AW(AW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wide_i(wide), .scale_i(scale),
    .base_i(base), .idx_i(idx), .mask_i(mask), .dst_i(dst_in),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wide_o(mem_wide),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .mask_o(mask_o), .dst_o(dst_o)
  );

  function automatic logic [63:0] memf(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A1234, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (cnt >= lat) begin
          ack = 1;
          rdata = memf(mem_addr);
          if (nreq < 16) alog[nreq] = mem_addr;
          nreq++;
          cnt = 0;
        end else begin
          ack = 0;
          cnt++;
        end
      end else begin
        ack = 0;
        cnt = 0;
      end
    end
  end

  function automatic logic [VW-1:0] mkidx(input int s, input bit w);
    logic [VW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'(i * 37 + s * 5 + 3) | (32'(s) << 20);
    if (w) for (int i = 0; i < 4; i++) v[i*64+32 +: 32] = 32'hDEAD0000 | 32'(i);
    return v;
  endfunction

  task automatic run(input bit w, input logic [1:0] sc, input logic [AW-1:0] b,
                     input logic [VW-1:0] ix, input logic [7:0] m, input logic [VW-1:0] d0,
                     input int lt, input bit poke, output logic [VW-1:0] res);
    logic [VW-1:0] exp;
    logic [7:0] em;
    logic [AW-1:0] ea [0:7];
    logic [63:0] o;
    int ne, n;
    em = w ? (m & 8'h0F) : m;
    exp = d0;
    ne = 0;
    for (int i = 0; i < (w ? 4 : 8); i++) begin
      if (em[i]) begin
        o = w ? ix[i*64 +: 64] : {32'b0, ix[i*32 +: 32]};
        o = o << sc;
        ea[ne] = b + o[AW-1:0];
        if (w) exp[i*64 +: 64] = memf(ea[ne]);
        else   exp[i*32 +: 32] = memf(ea[ne])[31:0];
        ne++;
      end
    end
    @(negedge clk);
    wide = w; scale = sc; base = b; idx = ix; mask = m; dst_in = d0;
    lat = lt; nreq = 0; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 300) begin
      if (poke && n == 2) begin start = 1; base = ~b; mask = 8'h00; wide = ~w; end
      else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    check(done, "R8 done reached", VW'(done), VW'(1));
    if (em == 0) begin
      check(n == 0, "R7 done one cycle after start", VW'(n), VW'(0));
      check(nreq == 0, "R7 no request", VW'(nreq), VW'(0));
    end
    check(dst_o == exp, w ? "R3 R6 wide result" : "R2 R6 narrow result", dst_o, exp);
    check(mask_o == 0, "R5 R8 mask empty at done", VW'(mask_o), VW'(0));
    check(nreq == ne, "R4 request count", VW'(nreq), VW'(ne));
    for (int k = 0; k < ne && k < nreq; k++)
      check(alog[k] == ea[k], w ? "R3 R4 address order" : "R2 R4 address order", VW'(alog[k]), VW'(ea[k]));
    res = dst_o;
    if (poke) start = 1;
    @(negedge clk);
    check(!done, "R8 done single pulse", VW'(done), VW'(0));
    check(!busy, poke ? "R9 start in done cycle ignored" : "R8 idle after done", VW'(busy), VW'(0));
    start = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] r, a1, b1, c1, d0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R1 reset controls", VW'({busy, done, mem_req}), VW'(0));
    check(mask_o == 0 && dst_o == 0, "R1 reset state", dst_o | VW'(mask_o), VW'(0));
    rst_n = 1;
    d0 = {8{32'hC0FFEE00}};
    for (int m = 0; m < 256; m++)
      run(1'b0, 2'(m % 4), 32'h1000_0000 + 32'(m) * 256, mkidx(m, 1'b0), 8'(m),
          d0 ^ VW'(m), m % 3, 1'b0, r);
    for (int m = 0; m < 64; m++)
      run(1'b1, 2'(m / 16), 32'h2000_0000 + 32'(m) * 64, mkidx(m, 1'b1),
          8'(m % 16) | 8'hA0, d0 ^ VW'(m * 7), (m % 4 == 3) ? 4 : m % 2, 1'b0, r);
    run(1'b0, 2'd2, 32'hFFFF_FF00, mkidx(9, 1'b0), 8'hFF, d0, 3, 1'b1, r);
    run(1'b1, 2'd3, 32'h0000_0040, mkidx(4, 1'b1), 8'h0F, d0, 2, 1'b1, r);
    run(1'b0, 2'd0, 32'h3000_0000, mkidx(5, 1'b0), 8'h00, d0, 0, 1'b1, r);
    run(1'b0, 2'd1, 32'h4000_0000, mkidx(11, 1'b0), 8'h06, d0, 1, 1'b0, a1);
    run(1'b0, 2'd1, 32'h4000_0000, mkidx(11, 1'b0), 8'hB0, a1, 2, 1'b0, b1);
    run(1'b0, 2'd1, 32'h4000_0000, mkidx(11, 1'b0), 8'hB6, d0, 0, 1'b0, c1);
    check(b1 == c1, "R10 narrow resume equals single gather", b1, c1);
    run(1'b1, 2'd2, 32'h5000_0000, mkidx(12, 1'b1), 8'h08, d0, 1, 1'b0, a1);
    run(1'b1, 2'd2, 32'h5000_0000, mkidx(12, 1'b1), 8'h05, a1, 0, 1'b0, b1);
    run(1'b1, 2'd2, 32'h5000_0000, mkidx(12, 1'b1), 8'h0D, d0, 3, 1'b0, c1);
    check(b1 == c1, "R10 wide resume equals single gather", b1, c1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule